// File: doc/BRIEF.md
# Overcharge Qualification Controller

This block is the digital decision core of a single-cell overcharge monitor. A measurement path delivers the cell voltage as a millivolt code with a one-cycle valid strobe. The block compares each sample against a programmable detect threshold. A charge-inhibit output is raised only after the cell has stayed above that threshold for a chosen qualification time. The output is lowered again as soon as a sample falls below a lower release threshold. The release threshold is the detect threshold minus a selectable hysteresis.

Time is counted in pulses of a free-running tick input. A parameter sets how many ticks make one second, so the same logic runs with a real low-rate oscillator or with a scaled tick. A test input, active low, shortens the qualification time by a factor of 64. The charge-inhibit signal leaves the block as a registered data/enable pair. The polarity is selectable, and so is the drive style: push-pull, or open-drain, which can only pull low.

Top module: `ovcharge_guard`

## Requirements
- R1: The detect threshold in mV is 3500 + 5 × `thr_code`. Codes above 300 act as 300, which gives 5000 mV. A sample counts as over the threshold only when it is strictly greater than the detect threshold.
- R2: The release threshold is the detect threshold minus 50 × (`hyst_sel` + 1) mV. While in overcharge, the first valid sample strictly below the release threshold returns the block to normal. Samples at or above the release threshold leave the overcharge state unchanged.
- R3: The qualification limit in ticks depends on `dly_sel`. Code 0 gives TICKS_PER_S ticks, code 1 gives 2 × TICKS_PER_S, and codes 2 and 3 give 4 × TICKS_PER_S. Overcharge is entered on the tick that brings the count of ticks, received after the over-threshold sample was registered, up to the limit. One tick fewer does not trip.
- R4: Before the trip, a valid sample at or below the detect threshold clears the count. A later over-threshold sample starts a new count of the full length.
- R5: While `test_n` is 0, the limit is the R3 limit divided by 64, rounded down, with a minimum of 1 tick.
- R6: When `act_low` is 0, the logical output level is high in overcharge and low otherwise. When `act_low` is 1, the level is inverted.
- R7: When `od_mode` is 0, `chg_oe` is 1 and `chg_out` equals the level. When `od_mode` is 1, `chg_out` is always 0 and `chg_oe` is 1 only when the level is low, so a high level is represented as high impedance.
- R8: During and after a synchronous reset the block is in the normal state with the count cleared. The pins then show the inactive level for the current `act_low` and `od_mode`.
- R9: The pins change on the clock edge after the state change. A release therefore shows one cycle after the releasing sample edge, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle time-base pulse |
| samp_valid | input | 1 | Strobe marking a new voltage sample |
| samp_mv | input | 13 | Cell voltage in millivolts |
| thr_code | input | 9 | Detect threshold step code |
| hyst_sel | input | 3 | Hysteresis select, 50 mV steps |
| dly_sel | input | 2 | Qualification delay select |
| test_n | input | 1 | Active-low delay shortening |
| act_low | input | 1 | Output polarity select |
| od_mode | input | 1 | Open-drain drive style select |
| chg_out | output | 1 | Charge-inhibit data |
| chg_oe | output | 1 | Charge-inhibit drive enable |

## Verification
A sample is registered at the edge that sees its strobe. Only ticks that arrive after that edge count. The state flips at the edge of the final tick, and the pins follow one edge later. The bench drives every input just after a falling edge and holds each tick for exactly one cycle. It then reads the pins at the falling edge that follows the pin update. For a trip, that falling edge is where the tick task returns after its last pulse. For a release, it comes one idle cycle after the releasing sample. The pins are also read once before that update, to show that nothing moves early. Each delay is probed one tick short of its limit and then exactly at the limit.

// File: rtl/ovd_pkg.sv
package ovd_pkg;
  localparam int MV_W         = 13;
  localparam int DET_BASE_MV  = 3500;
  localparam int DET_STEP_MV  = 5;
  localparam int DET_MAX_CODE = 300;
  localparam int HYST_STEP_MV = 50;
  localparam int TEST_SHIFT   = 6;

  typedef enum logic [1:0] {
    DLY_1S     = 2'd0,
    DLY_2S     = 2'd1,
    DLY_4S     = 2'd2,
    DLY_4S_ALT = 2'd3
  } dly_e;
endpackage

// File: rtl/ovd_thresholds.sv
module ovd_thresholds
  import ovd_pkg::*;
#(
  parameter int CODE_W = 9,
  parameter int HYST_W = 3
) (
  input  logic [CODE_W-1:0] thr_code,
  input  logic [HYST_W-1:0] hyst_sel,
  output logic [MV_W-1:0]   det_mv,
  output logic [MV_W-1:0]   rel_mv
);
  localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(DET_MAX_CODE);

  logic [CODE_W-1:0] code_sat;
  logic [MV_W-1:0]   hyst_mv;

  // R1: saturate the step code, then scale
  assign code_sat = (thr_code > MAX_CODE) ? MAX_CODE : thr_code;
  assign det_mv   = MV_W'(DET_BASE_MV) + MV_W'(code_sat) * MV_W'(DET_STEP_MV);
  // R2: release sits a whole number of hysteresis steps below detect
  assign hyst_mv  = (MV_W'(hyst_sel) + MV_W'(1)) * MV_W'(HYST_STEP_MV);
  assign rel_mv   = det_mv - hyst_mv;
endmodule

// File: rtl/ovd_persist_timer.sv
module ovd_persist_timer
  import ovd_pkg::*;
#(
  parameter int TICKS_PER_S = 32768
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       adv,
  input  logic [1:0] dly_sel,
  input  logic       test_n,
  output logic       hit
);
  localparam int LIM_W = $clog2(4 * TICKS_PER_S + 1);

  logic [LIM_W-1:0] base_lim;
  logic [LIM_W-1:0] short_lim;
  logic [LIM_W-1:0] limit;
  logic [LIM_W-1:0] cnt;
  logic [LIM_W-1:0] nxt;

  // R3: limit from the delay select
  always_comb begin
    case (dly_e'(dly_sel))
      DLY_1S:  base_lim = LIM_W'(TICKS_PER_S);
      DLY_2S:  base_lim = LIM_W'(2 * TICKS_PER_S);
      default: base_lim = LIM_W'(4 * TICKS_PER_S);
    endcase
  end

  // R5: test mode divides by 64 but never below one tick
  assign short_lim = base_lim >> TEST_SHIFT;
  assign limit     = test_n ? base_lim
                            : ((short_lim == '0) ? LIM_W'(1) : short_lim);

  assign nxt = cnt + LIM_W'(1);
  assign hit = adv && !clr && (nxt >= limit);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (adv) begin
      cnt <= hit ? '0 : nxt;
    end
  end

  // R4: a clear request leaves the count at zero on the next cycle
  p_clear_empties_r4: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
endmodule

// File: rtl/ovd_pin_stage.sv
module ovd_pin_stage (
  input  logic clk,
  input  logic rst,
  input  logic ovc,
  input  logic act_low,
  input  logic od_mode,
  output logic chg_out,
  output logic chg_oe
);
  logic level;

  // R6: logical level, forced inactive while in reset (R8)
  assign level = (rst ? 1'b0 : ovc) ^ act_low;

  // R7: drive style
  always_ff @(posedge clk) begin
    if (od_mode) begin
      chg_out <= 1'b0;
      chg_oe  <= ~level;
    end else begin
      chg_out <= level;
      chg_oe  <= 1'b1;
    end
  end

  p_od_never_high_r7: assert property (@(posedge clk) disable iff (rst)
    od_mode |=> !chg_out);
  p_pushpull_enabled_r7: assert property (@(posedge clk) disable iff (rst)
    !od_mode |=> chg_oe);
endmodule

// File: rtl/ovcharge_guard.sv
module ovcharge_guard
  import ovd_pkg::*;
#(
  parameter int TICKS_PER_S = 32768,
  parameter int CODE_W      = 9,
  parameter int HYST_W      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              samp_valid,
  input  logic [MV_W-1:0]   samp_mv,
  input  logic [CODE_W-1:0] thr_code,
  input  logic [HYST_W-1:0] hyst_sel,
  input  logic [1:0]        dly_sel,
  input  logic              test_n,
  input  logic              act_low,
  input  logic              od_mode,
  output logic              chg_out,
  output logic              chg_oe
);
  logic [MV_W-1:0] det_mv;
  logic [MV_W-1:0] rel_mv;
  logic            above_q;
  logic            ovc_q;
  logic            drop_now;
  logic            rel_now;
  logic            tmr_clr;
  logic            tmr_adv;
  logic            tmr_hit;

  ovd_thresholds #(.CODE_W(CODE_W), .HYST_W(HYST_W)) u_thr (
    .thr_code (thr_code),
    .hyst_sel (hyst_sel),
    .det_mv   (det_mv),
    .rel_mv   (rel_mv)
  );

  assign drop_now = samp_valid && (samp_mv <= det_mv);
  assign rel_now  = samp_valid && (samp_mv <  rel_mv);
  assign tmr_clr  = ovc_q || !above_q || drop_now;
  assign tmr_adv  = tick && above_q;

  ovd_persist_timer #(.TICKS_PER_S(TICKS_PER_S)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .clr     (tmr_clr),
    .adv     (tmr_adv),
    .dly_sel (dly_sel),
    .test_n  (test_n),
    .hit     (tmr_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      above_q <= 1'b0;
      ovc_q   <= 1'b0;
    end else begin
      if (samp_valid) above_q <= (samp_mv > det_mv);
      if (ovc_q) begin
        if (rel_now) ovc_q <= 1'b0;
      end else if (tmr_hit) begin
        ovc_q <= 1'b1;
      end
    end
  end

  ovd_pin_stage u_pin (
    .clk     (clk),
    .rst     (rst),
    .ovc     (ovc_q),
    .act_low (act_low),
    .od_mode (od_mode),
    .chg_out (chg_out),
    .chg_oe  (chg_oe)
  );

  p_trip_needs_above_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ovc_q) |-> $past(above_q));
  p_at_detect_blocks_r4: assert property (@(posedge clk) disable iff (rst)
    (!ovc_q && drop_now) |=> !ovc_q);
  p_release_r2: assert property (@(posedge clk) disable iff (rst)
    (ovc_q && rel_now) |=> !ovc_q);
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (ovc_q && !rel_now) |=> ovc_q);
  p_pin_follows_r9: assert property (@(posedge clk) disable iff (rst)
    (!od_mode && !act_low) |=> (chg_out == $past(ovc_q)));
endmodule

// File: tb/ovcharge_guard_test.sv
module ovcharge_guard_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int TPS = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        samp_valid = 1'b0;
  logic [12:0] samp_mv = '0;
  logic [8:0]  thr_code = '0;
  logic [2:0]  hyst_sel = '0;
  logic [1:0]  dly_sel = '0;
  logic        test_n = 1'b1;
  logic        act_low = 1'b0;
  logic        od_mode = 1'b0;
  logic        chg_out;
  logic        chg_oe;

  int compared = 0;
  int mismatched = 0;

  always #2.5 clk = ~clk;

  ovcharge_guard #(.TICKS_PER_S(TPS)) uut (
    .clk(clk), .rst(rst), .tick(tick), .samp_valid(samp_valid),
    .samp_mv(samp_mv), .thr_code(thr_code), .hyst_sel(hyst_sel),
    .dly_sel(dly_sel), .test_n(test_n), .act_low(act_low),
    .od_mode(od_mode), .chg_out(chg_out), .chg_oe(chg_oe)
  );

  typedef struct packed {
    logic [8:0]  code;
    logic [12:0] mv;
    logic        trip;
  } vec_t;

  // R1 boundary vectors, run in test mode with a two-tick limit
  localparam vec_t VECS [8] = '{
    '{9'd0,   13'd3500, 1'b0},
    '{9'd0,   13'd3501, 1'b1},
    '{9'd100, 13'd4000, 1'b0},
    '{9'd100, 13'd4005, 1'b1},
    '{9'd300, 13'd5000, 1'b0},
    '{9'd300, 13'd5001, 1'b1},
    '{9'd400, 13'd5000, 1'b0},
    '{9'd400, 13'd5001, 1'b1}
  };

  function automatic logic [1:0] pins(input logic on, input logic al, input logic od);
    logic lvl;
    lvl = on ^ al;
    return od ? {1'b0, ~lvl} : {lvl, 1'b1};
  endfunction

  task automatic chk(input string tag, input logic [1:0] exp);
    compared++;
    if ({chg_out, chg_oe} !== exp) begin
      mismatched++;
      $display("FAIL %s: actual out/oe=%b%b expected=%b%b", tag, chg_out, chg_oe, exp[1], exp[0]);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc(2);
    rst = 1'b0;
  endtask

  task automatic send(input logic [12:0] mv);
    samp_mv = mv;
    samp_valid = 1'b1;
    cyc(1);
    samp_valid = 1'b0;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      tick = 1'b1;
      cyc(1);
      tick = 1'b0;
      cyc(1);
    end
  endtask

  // normal-mode delay probe: one tick short, then at the limit
  task automatic delay_probe(input logic [1:0] sel, input logic tn, input int lim, input string tag);
    dly_sel = sel;
    test_n = tn;
    thr_code = 9'd100;
    do_reset();
    send(13'd4100);
    ticks(lim - 1);
    chk({tag, " one tick short"}, pins(1'b0, 1'b0, 1'b0));
    ticks(1);
    chk({tag, " at limit"}, pins(1'b1, 1'b0, 1'b0));
  endtask

  initial begin
    cyc(1);
    // R8: reset state for every polarity and drive style
    for (int k = 0; k < 4; k++) begin
      act_low = k[0];
      od_mode = k[1];
      do_reset();
      chk("R8 reset inactive", pins(1'b0, act_low, od_mode));
    end
    act_low = 1'b0;
    od_mode = 1'b0;

    // R1 table walk
    for (int i = 0; i < 8; i++) begin
      thr_code = VECS[i].code;
      hyst_sel = 3'd0;
      dly_sel = 2'd0;
      test_n = 1'b0;
      do_reset();
      send(VECS[i].mv);
      ticks(2);
      chk($sformatf("R1 vector %0d", i), pins(VECS[i].trip, 1'b0, 1'b0));
    end

    // R3 full delays
    delay_probe(2'd0, 1'b1, TPS,     "R3 1s");
    delay_probe(2'd1, 1'b1, 2 * TPS, "R3 2s");
    delay_probe(2'd2, 1'b1, 4 * TPS, "R3 4s");
    delay_probe(2'd3, 1'b1, 4 * TPS, "R3 code3");
    // R5 test mode
    delay_probe(2'd1, 1'b0, 4, "R5 2s/64");
    delay_probe(2'd2, 1'b0, 8, "R5 4s/64");

    // R4 dropout restarts the count
    dly_sel = 2'd0;
    test_n = 1'b1;
    thr_code = 9'd100;
    hyst_sel = 3'd1;
    do_reset();
    send(13'd4100);
    ticks(100);
    send(13'd4000);
    send(13'd4100);
    ticks(TPS - 1);
    chk("R4 restart not yet tripped", pins(1'b0, 1'b0, 1'b0));
    ticks(1);
    chk("R4 restart full count", pins(1'b1, 1'b0, 1'b0));

    // R2 release thresholds: detect 4000, release 3900
    send(13'd4000);
    cyc(1);
    chk("R2 at detect stays on", pins(1'b1, 1'b0, 1'b0));
    send(13'd3900);
    cyc(1);
    chk("R2 at release stays on", pins(1'b1, 1'b0, 1'b0));
    send(13'd3899);
    chk("R9 pins not yet moved", pins(1'b1, 1'b0, 1'b0));
    cyc(1);
    chk("R2 below release clears", pins(1'b0, 1'b0, 1'b0));

    // R2 largest hysteresis: release 3600
    hyst_sel = 3'd7;
    test_n = 1'b0;
    do_reset();
    send(13'd4100);
    ticks(2);
    send(13'd3650);
    cyc(1);
    chk("R2 wide hysteresis holds", pins(1'b1, 1'b0, 1'b0));
    send(13'd3599);
    cyc(1);
    chk("R2 wide hysteresis release", pins(1'b0, 1'b0, 1'b0));

    // R6 / R7 tripped pins per polarity and style
    for (int k = 1; k < 4; k++) begin
      act_low = k[0];
      od_mode = k[1];
      do_reset();
      send(13'd4100);
      ticks(2);
      chk($sformatf("R6 R7 tripped al=%0d od=%0d", k[0], k[1]), pins(1'b1, act_low, od_mode));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL R3 watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule